// File: doc/BRIEF.md
# Serial-In Latched Eight-Channel Output Driver

This block is the logic core of a serial-to-parallel output driver. A serial bit stream is shifted into a chain of stages, one stage per output channel, on each rising edge of a slow serial clock. The last stage is brought out as a serial output, so several drivers can be chained. A level-sensitive strobe copies the shift chain into a holding latch. While the strobe is high, the latch follows the chain. When the strobe is low, the latch keeps its value. The latch contents drive the channel outputs through a gate. That gate turns every channel off while the active-high disable input is high, while a sticky overcurrent flag is set, or while a thermal fault input is high.

The block runs on a fast system clock that oversamples all six control inputs. The serial clock, serial data, strobe, disable and both fault inputs pass through the same synchroniser chain, so they keep their relative timing. Shifting happens on a detected rising edge of the synchronised serial clock. An overcurrent indication sets a flag that stays set after the fault goes away. A rising edge on the disable input clears the flag, but only if the overcurrent input is low at that moment. A thermal fault is not remembered.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears the shift chain, the latch, the overcurrent flag and all outputs to 0.
- R2: Each input passes through SYNC_STAGES synchroniser flops. A serial-clock rise applied to the pins moves the chain on the (SYNC_STAGES+1)-th system clock edge after the change. The serial data level that passes through the synchroniser alongside that rise enters stage 0.
- R3: On each detected serial-clock rise, stage k moves into stage k+1. sdata_out always shows the last stage (index CHANNELS-1) and changes only after a detected rise.
- R4: While the synchronised strobe is high, the latch takes the chain value on every system clock. While the strobe is low, the latch holds its value.
- R5: While the synchronised disable is high, drive_out is all 0 from the next cycle on. Disable changes neither the latch nor the chain, so the latched pattern reappears when disable drops.
- R6: drive_out is registered. Bit n equals latch bit n when disable, the overcurrent flag and the thermal fault are all low. Bit 0 belongs to the stage fed by the serial input, and bit CHANNELS-1 belongs to the serial output stage.
- R7: A synchronised high on the overcurrent input sets the flag (fault_flag_out = 1). While the flag is set, drive_out is all 0.
- R8: The flag stays set until a rising edge of the synchronised disable occurs while the synchronised overcurrent input is low. A disable edge seen while the overcurrent input is high does not clear the flag.
- R9: A high thermal fault input forces drive_out to 0 only while it is present. It does not set the flag, and the outputs return as soon as it drops.
- R10: A serial clock held high causes exactly one shift, however the serial data changes while the clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdata_in | input | 1 | Serial data in |
| strobe_in | input | 1 | Level-sensitive latch strobe |
| disable_in | input | 1 | High turns all outputs off; a rising edge clears the overcurrent flag |
| ocp_fault_in | input | 1 | Overcurrent indication |
| thermal_fault_in | input | 1 | Thermal limit indication, not latched |
| drive_out | output | CHANNELS | Channel output enables, 1 = on |
| sdata_out | output | 1 | Last chain stage, used for chaining |
| fault_flag_out | output | 1 | Sticky overcurrent flag |

## Verification
Two functions can fall in the same cycle: a disable rising edge that asks to clear the flag, and an overcurrent input that sets it. The bench provokes this by pulsing disable while the overcurrent input is still high. It expects the flag to stay set and then clear on a later pulse taken after the fault has dropped. A second overlap occurs when a strobe and shifting happen while disable is high. The bench judges this by comparing the output pattern seen once disable drops with a behavioural model that is updated on every clock.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic strobe;
    logic dis;
    logic ocp;
    logic therm;
  } sld_ctrl_t;

  localparam int SLD_CTRL_W = $bits(sld_ctrl_t);
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= '0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         din,
  output logic [N-1:0] q
);
  localparam int LOW_W = N - 1;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) q <= {q[LOW_W-1:0], din};
  end
endmodule

// File: rtl/sld_hold_latch.sv
module sld_hold_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (open_en) q <= d;
  end
endmodule

// File: rtl/sld_out_stage.sv
module sld_out_stage #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lat,
  input  logic         dis,
  input  logic         therm,
  input  logic         ocp,
  input  logic         clr_req,
  output logic [N-1:0] drive,
  output logic         flag
);
  logic allow;

  assign allow = ~dis & ~flag & ~therm;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive <= '0;
      flag  <= 1'b0;
    end else begin
      drive <= allow ? lat : '0;
      if (ocp)          flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_in,
  input  logic                sdata_in,
  input  logic                strobe_in,
  input  logic                disable_in,
  input  logic                ocp_fault_in,
  input  logic                thermal_fault_in,
  output logic [CHANNELS-1:0] drive_out,
  output logic                sdata_out,
  output logic                fault_flag_out
);
  localparam int TAIL = CHANNELS - 1;

  sld_ctrl_t             ctl_raw;
  sld_ctrl_t             ctl_s;
  logic [SLD_CTRL_W-1:0] raw_vec;
  logic [SLD_CTRL_W-1:0] s_vec;

  logic                  sclk_q;
  logic                  dis_q;
  logic                  sclk_rise;
  logic                  dis_rise;
  logic                  dis_s;
  logic                  ocp_s;
  logic                  therm_s;
  logic [CHANNELS-1:0]   chain;
  logic [CHANNELS-1:0]   held;

  assign ctl_raw.sclk   = sclk_in;
  assign ctl_raw.sdata  = sdata_in;
  assign ctl_raw.strobe = strobe_in;
  assign ctl_raw.dis    = disable_in;
  assign ctl_raw.ocp    = ocp_fault_in;
  assign ctl_raw.therm  = thermal_fault_in;
  assign raw_vec        = ctl_raw;

  sld_sync #(.W(SLD_CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_vec),
    .q   (s_vec)
  );

  assign ctl_s   = sld_ctrl_t'(s_vec);
  assign dis_s   = ctl_s.dis;
  assign ocp_s   = ctl_s.ocp;
  assign therm_s = ctl_s.therm;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      sclk_q <= ctl_s.sclk;
      dis_q  <= dis_s;
    end
  end

  assign sclk_rise = ctl_s.sclk & ~sclk_q;
  assign dis_rise  = dis_s & ~dis_q;

  sld_shift #(.N(CHANNELS)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .step (sclk_rise),
    .din  (ctl_s.sdata),
    .q    (chain)
  );

  sld_hold_latch #(.N(CHANNELS)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .open_en (ctl_s.strobe),
    .d       (chain),
    .q       (held)
  );

  sld_out_stage #(.N(CHANNELS)) u_out (
    .clk     (clk),
    .rst     (rst),
    .lat     (held),
    .dis     (dis_s),
    .therm   (therm_s),
    .ocp     (ocp_s),
    .clr_req (dis_rise),
    .drive   (drive_out),
    .flag    (fault_flag_out)
  );

  assign sdata_out = chain[TAIL];
endmodule

// File: rtl/serial_latch_driver_chk.sv
module serial_latch_driver_chk #(
  parameter int CHANNELS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [CHANNELS-1:0] drive_out,
  input logic                sdata_out,
  input logic                fault_flag_out,
  input logic                dis_s,
  input logic                dis_q,
  input logic                ocp_s,
  input logic                therm_s,
  input logic                sclk_rise
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (drive_out == '0 && !fault_flag_out && !sdata_out));

  p_serial_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(sdata_out));

  p_disable_off_r5: assert property (@(posedge clk) disable iff (rst)
    dis_s |=> drive_out == '0);

  p_ocp_sets_r7: assert property (@(posedge clk) disable iff (rst)
    ocp_s |=> fault_flag_out);

  p_flag_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    fault_flag_out |=> drive_out == '0);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_flag_out && !(dis_s && !dis_q)) |=> fault_flag_out);

  p_clear_needs_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_flag_out) |-> $past(dis_s && !dis_q && !ocp_s));

  p_thermal_off_r9: assert property (@(posedge clk) disable iff (rst)
    therm_s |=> drive_out == '0);
endmodule

bind serial_latch_driver serial_latch_driver_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .drive_out      (drive_out),
  .sdata_out      (sdata_out),
  .fault_flag_out (fault_flag_out),
  .dis_s          (dis_s),
  .dis_q          (dis_q),
  .ocp_s          (ocp_s),
  .therm_s        (therm_s),
  .sclk_rise      (sclk_rise)
);

// File: tb/serial_latch_driver_tb.sv
`timescale 1ns/1ps
module serial_latch_driver_tb;
  localparam int N    = 8;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0, sdata = 1'b0, strobe = 1'b0;
  logic         dis = 1'b0, ocp = 1'b0, therm = 1'b0;
  logic [N-1:0] drive_out;
  logic         sdata_out, fault_flag_out;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  serial_latch_driver #(.CHANNELS(N), .SYNC_STAGES(SYNC)) u_dut (
    .clk              (clk),
    .rst              (rst),
    .sclk_in          (sclk),
    .sdata_in         (sdata),
    .strobe_in        (strobe),
    .disable_in       (dis),
    .ocp_fault_in     (ocp),
    .thermal_fault_in (therm),
    .drive_out        (drive_out),
    .sdata_out        (sdata_out),
    .fault_flag_out   (fault_flag_out)
  );

  // Behavioural reference: delayed input samples in a queue, state as integers.
  logic [5:0]   dq[$];
  logic [5:0]   cur;
  logic         m_prev_sclk, m_prev_dis, m_flag, m_valid = 1'b0;
  logic [N-1:0] m_sr, m_lat, m_drv;

  always @(posedge clk) begin
    if (rst) begin
      m_sr = '0; m_lat = '0; m_drv = '0; m_flag = 1'b0;
      m_prev_sclk = 1'b0; m_prev_dis = 1'b0; cur = '0;
      dq.delete();
      for (int i = 0; i < SYNC - 1; i++) dq.push_back(6'b0);
      m_valid = 1'b1;
    end else begin
      logic [N-1:0] n_sr, n_lat, n_drv;
      logic n_flag;
      // cur bits: 5 sclk, 4 sdata, 3 strobe, 2 dis, 1 ocp, 0 therm
      n_sr   = (cur[5] && !m_prev_sclk) ? ((m_sr << 1) | N'(cur[4])) : m_sr;
      n_lat  = cur[3] ? m_sr : m_lat;
      n_drv  = (!cur[2] && !m_flag && !cur[0]) ? m_lat : '0;
      n_flag = cur[1] ? 1'b1 : ((cur[2] && !m_prev_dis) ? 1'b0 : m_flag);
      m_prev_sclk = cur[5];
      m_prev_dis  = cur[2];
      m_sr = n_sr; m_lat = n_lat; m_drv = n_drv; m_flag = n_flag;
      cur = dq.pop_front();
      dq.push_back({sclk, sdata, strobe, dis, ocp, therm});
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      vectors++;
      if (drive_out !== m_drv || sdata_out !== m_sr[N-1] || fault_flag_out !== m_flag) begin
        miscompares++;
        $display("FAIL %s model: drive=%h/%h sout=%b/%b flag=%b/%b (actual/expected)",
                 phase, drive_out, m_drv, sdata_out, m_sr[N-1], fault_flag_out, m_flag);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdata = b; wait_n(4);
    sclk = 1'b1; wait_n(8);
    sclk = 1'b0; wait_n(8);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_strobe();
    wait_n(15); strobe = 1'b1; wait_n(6); strobe = 1'b0; wait_n(6);
  endtask

  task automatic pulse_disable();
    dis = 1'b1; wait_n(6); dis = 1'b0; wait_n(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    check("R1 drive after reset", 32'(drive_out), 32'h0);
    check("R1 flag after reset", 32'(fault_flag_out), 32'h0);
    check("R1 sout after reset", 32'(sdata_out), 32'h0);

    phase = "R6";
    send_byte(8'hA5);
    pulse_strobe();
    check("R6 drive shows latched A5", 32'(drive_out), 32'hA5);
    check("R3 sout is last stage", 32'(sdata_out), 32'h1);

    phase = "R4";
    send_byte(8'h3C);
    check("R4 latch holds with strobe low", 32'(drive_out), 32'hA5);
    check("R3 sout after 3C", 32'(sdata_out), 32'h0);

    phase = "R10";
    sdata = 1'b1; wait_n(4);
    sclk = 1'b1; wait_n(4);
    for (int i = 0; i < 30; i++) begin sdata = ~sdata; wait_n(1); end
    sclk = 1'b0; wait_n(8);
    pulse_strobe();
    check("R10 single shift while clock high", 32'(drive_out), 32'h79);

    phase = "R5";
    dis = 1'b1; wait_n(6);
    check("R5 disabled outputs off", 32'(drive_out), 32'h0);
    send_byte(8'h0F);
    pulse_strobe();
    check("R5 still off after strobe", 32'(drive_out), 32'h0);
    dis = 1'b0; wait_n(6);
    check("R5 storage kept through disable", 32'(drive_out), 32'h0F);

    phase = "R2";
    send_byte(8'h40);
    sdata = 1'b0; wait_n(4);
    sclk = 1'b1;
    wait_n(SYNC);
    check("R2 no shift before sync latency", 32'(sdata_out), 32'h0);
    wait_n(1);
    check("R2 shift after sync latency", 32'(sdata_out), 32'h1);
    wait_n(8); sclk = 1'b0; wait_n(8);

    phase = "R7";
    ocp = 1'b1; wait_n(6);
    check("R7 flag set", 32'(fault_flag_out), 32'h1);
    check("R7 outputs off", 32'(drive_out), 32'h0);
    phase = "R8";
    pulse_disable();
    check("R8 clear ignored while fault present", 32'(fault_flag_out), 32'h1);
    ocp = 1'b0; wait_n(6);
    check("R8 flag sticky after fault drops", 32'(fault_flag_out), 32'h1);
    check("R8 outputs still off", 32'(drive_out), 32'h0);
    pulse_disable();
    check("R8 flag cleared by disable pulse", 32'(fault_flag_out), 32'h0);
    check("R8 outputs restored", 32'(drive_out), 32'h0F);

    phase = "R9";
    therm = 1'b1; wait_n(6);
    check("R9 thermal forces off", 32'(drive_out), 32'h0);
    check("R9 thermal not latched in flag", 32'(fault_flag_out), 32'h0);
    therm = 1'b0; wait_n(6);
    check("R9 outputs return", 32'(drive_out), 32'h0F);

    phase = "R1";
    rst = 1'b1; wait_n(2);
    check("R1 drive cleared by later reset", 32'(drive_out), 32'h0);
    rst = 1'b0; wait_n(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule